// File: doc/BRIEF.md
# Serial Bit Receiver

The block turns a serial bit stream into a parallel word. A start qualifier tells it when a frame begins. From that cycle on it samples the data input once per clock. It keeps each sample in a word register at the position given by a bit pointer. After the last bit it raises a one-cycle valid pulse, and the assembled word is on the output in that cycle.

The controller is a Moore machine. It counts bit positions with a pointer, not with a timer. The state register, the pointer and the word register all update on the same rising clock edge. The machine leaves the idle state into one of two store states, and the value of the first bit chooses which one. The first bit is therefore kept without an extra capture cycle. The valid cycle also accepts a start, so frames can follow one another with no gap.

Top module: `serial_word_rx`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next edge clears the word output to zero, drops valid and returns the machine to idle.
- R2: When the machine is in idle and start is sampled low, it stays idle and valid stays low, whatever the data input does.
- R3: The data bit sampled on the same edge as the start qualifier becomes bit 0 of the word; it is not lost.
- R4: One data bit is sampled per clock. With the default LSB-first order, bit j of the word is the value sampled j edges after the start edge.
- R5: Valid is high for exactly one cycle. It rises after the edge that comes WORD_W edges after the start edge, and the complete word is on the output in that cycle.
- R6: During a frame the start input is ignored: toggling it changes neither the received word nor the cycle of the valid pulse.
- R7: A start sampled during the valid cycle begins a new frame at once. Its bit 0 is the data input in that cycle, and the next valid pulse follows exactly WORD_W low cycles later.
- R8: While the machine is idle the word output holds its last value.
- R9: A reset in the middle of a frame abandons it. No valid pulse follows, and a later full frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; everything updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start qualifier, sampled in idle or in the valid cycle |
| sdata_i | input | 1 | Serial data bit, one per clock |
| word_o | output | WORD_W | Assembled parallel word |
| word_valid_o | output | 1 | One-cycle pulse marking a complete word |

## Verification
Two functions can fall in the same cycle: the valid pulse that ends one frame and the start detection that opens the next. The bench provokes this by driving start and the next frame's first bit during the valid cycle itself. It then judges three things: that the finished word is intact in that cycle, that the new word's bit 0 is the value driven in that cycle, and that exactly WORD_W low cycles separate the two pulses. Noise on the start input in the middle of a frame is mixed into the same runs.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_KEEP0 = 2'd1,
      RX_KEEP1 = 2'd2,
      RX_DONE  = 2'd3
   } rx_state_e;

   localparam bit ORDER_LSB_FIRST = 1'b1;
   localparam bit ORDER_MSB_FIRST = 1'b0;
endpackage

// File: rtl/serial_word_rx_ptr.sv
module serial_word_rx_ptr #(
   parameter int WORD_W = 8,
   localparam int PTR_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             last_o
);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(WORD_W - 1);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         ptr_q <= '0;
      end else if (step_i) begin
         ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + PTR_W'(1);
      end
   end

   assign ptr_o  = ptr_q;
   assign last_o = (ptr_q == LAST_IDX);

   // R4: one position advance per stored bit
   assert_ptr_advance_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && !clr_i && !last_o) |=> (ptr_o == $past(ptr_o) + PTR_W'(1)));

   // R4: the pointer never leaves the word
   assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (ptr_o <= LAST_IDX));
endmodule

// File: rtl/serial_word_rx_fsm.sv
module serial_word_rx_fsm
   import serial_word_rx_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      start_i,
   input  logic      sdata_i,
   input  logic      last_i,
   output rx_state_e state_o,
   output logic      store_o,
   output logic      bit_o,
   output logic      ptr_clr_o,
   output logic      valid_o
);
   rx_state_e state_q, state_d;
   logic      waiting;

   assign waiting = (state_q == RX_IDLE) || (state_q == RX_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RX_IDLE, RX_DONE: begin
            if (start_i) state_d = sdata_i ? RX_KEEP1 : RX_KEEP0;
            else         state_d = RX_IDLE;
         end
         RX_KEEP0, RX_KEEP1: begin
            if (last_i) state_d = RX_DONE;
            else        state_d = sdata_i ? RX_KEEP1 : RX_KEEP0;
         end
         default: state_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= RX_IDLE;
      else       state_q <= state_d;
   end

   // Moore outputs: decoded from the state register only
   assign state_o   = state_q;
   assign store_o   = (state_q == RX_KEEP0) || (state_q == RX_KEEP1);
   assign bit_o     = (state_q == RX_KEEP1);
   assign ptr_clr_o = waiting;
   assign valid_o   = (state_q == RX_DONE);

   // R5: the valid pulse lasts one cycle
   assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> !valid_o);

   // R2: no start keeps the machine idle
   assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      ((state_o == RX_IDLE) && !start_i) |=> (state_o == RX_IDLE) && !valid_o);

   // R6: a running frame continues whatever start does
   assert_frame_continues_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (store_o && !last_i) |=> store_o);

   // R5: the last stored bit is followed by valid
   assert_last_then_valid_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (store_o && last_i) |=> valid_o);
endmodule

// File: rtl/serial_word_rx_word.sv
module serial_word_rx_word #(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = 1'b1,
   localparam int PTR_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic              bit_i,
   input  logic [PTR_W-1:0]  ptr_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] word_q;

   for (genvar g = 0; g < WORD_W; g++) begin : g_bit
      localparam int SLOT = LSB_FIRST ? g : (WORD_W - 1 - g);
      localparam logic [PTR_W-1:0] SLOT_IDX = PTR_W'(SLOT);
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            word_q[g] <= 1'b0;
         end else if (wr_i && (ptr_i == SLOT_IDX)) begin
            word_q[g] <= bit_i;
         end
      end
   end

   assign word_o = word_q;
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
   import serial_word_rx_pkg::*;
#(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = ORDER_LSB_FIRST,
   localparam int PTR_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic              sdata_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o
);
   if (WORD_W < 2) begin : g_bad_width
      $error("serial_word_rx: WORD_W must be at least 2");
   end
   if (WORD_W > 1024) begin : g_big_width
      $error("serial_word_rx: WORD_W above 1024 is not supported");
   end

   rx_state_e        state;
   logic             store, bit_val, ptr_clr, last;
   logic [PTR_W-1:0] ptr;

   serial_word_rx_fsm u_fsm (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .start_i   (start_i),
      .sdata_i   (sdata_i),
      .last_i    (last),
      .state_o   (state),
      .store_o   (store),
      .bit_o     (bit_val),
      .ptr_clr_o (ptr_clr),
      .valid_o   (word_valid_o)
   );

   serial_word_rx_ptr #(.WORD_W(WORD_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .clr_i  (ptr_clr),
      .step_i (store),
      .ptr_o  (ptr),
      .last_o (last)
   );

   serial_word_rx_word #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_word (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .wr_i   (store),
      .bit_i  (bit_val),
      .ptr_i  (ptr),
      .word_o (word_o)
   );

   // R8: the word is frozen while the machine idles
   assert_idle_word_stable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (state == RX_IDLE) |=> $stable(word_o));

   // R3: a frame opens in the first store state with the pointer at zero
   assert_first_slot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      ((state == RX_IDLE || state == RX_DONE) && start_i) |=> (store && ptr == '0));
endmodule

// File: tb/tb_serial_word_rx.sv
module tb_serial_word_rx;
   localparam int W = 8;
   localparam int NV = 8;
   // stimulus word, expected word, back-to-back follow flag
   localparam logic [W-1:0] VEC_IN  [NV] = '{8'h01, 8'hFE, 8'hA5, 8'h5A,
                                             8'h00, 8'hFF, 8'h3C, 8'h81};
   localparam logic [W-1:0] VEC_EXP [NV] = '{8'h01, 8'hFE, 8'hA5, 8'h5A,
                                             8'h00, 8'hFF, 8'h3C, 8'h81};
   localparam bit           VEC_B2B [NV] = '{1'b0, 1'b1, 1'b1, 1'b0,
                                             1'b1, 1'b0, 1'b1, 1'b0};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         sdata = 1'b0;
   logic [W-1:0] word;
   logic         valid;
   int           checks = 0;
   int           errors = 0;
   int           cycles = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   serial_word_rx #(.WORD_W(W)) dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .start_i      (start),
      .sdata_i      (sdata),
      .word_o       (word),
      .word_valid_o (valid)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         finish_run();
      end
   end

   // Called at a negedge; returns at the negedge of the valid cycle.
   task automatic send(input logic [W-1:0] w, input bit noise);
      start = 1'b1;
      sdata = w[0];
      @(posedge clk);
      for (int j = 1; j < W; j++) begin
         @(negedge clk);
         check(valid == 1'b0, "R5 no early valid", valid, 0);
         start = noise ? j[0] : 1'b0;   // R6: start noise mid-frame
         sdata = w[j];
         @(posedge clk);
      end
      @(negedge clk);
      check(valid == 1'b0, "R5 no early valid", valid, 0);
      start = 1'b0;
      sdata = ~w[0];
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [W-1:0] held;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(valid == 1'b0, "R1 valid after reset", valid, 0);
      check(word == '0, "R1 word after reset", word, 0);
      rst = 1'b0;

      // Vector table walk
      for (int k = 0; k < NV; k++) begin
         send(VEC_IN[k], k[0]);
         check(valid == 1'b1, "R5 valid pulse", valid, 1);
         check(word == VEC_EXP[k], "R4 word value", word, VEC_EXP[k]);
         check(word[0] == VEC_EXP[k][0], "R3 first bit kept", word[0], VEC_EXP[k][0]);
         if (!VEC_B2B[k]) begin
            start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(valid == 1'b0, "R5 single pulse", valid, 0);
         end
         // with VEC_B2B set the next send starts in the valid cycle (R7)
      end

      // R2 and R8: idle with toggling data, no start
      held = word;
      for (int c = 0; c < 6; c++) begin
         start = 1'b0;
         sdata = c[0];
         @(posedge clk);
         @(negedge clk);
         check(valid == 1'b0, "R2 idle without start", valid, 0);
         check(word == held, "R8 word held in idle", word, held);
      end

      // R7: explicit back-to-back with pulse spacing measured
      send(8'hC3, 1'b1);
      check(word == 8'hC3, "R7 first word", word, 8'hC3);
      begin
         int gap;
         gap = 0;
         start = 1'b1;
         sdata = 1'b0;
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         while (!valid && gap < 3 * W) begin
            sdata = 1'b1;
            gap++;
            @(posedge clk);
            @(negedge clk);
         end
         check(gap == W, "R7 low cycles between pulses", gap, W);
         check(word == 8'hFE, "R7 second word bit 0 from valid cycle", word, 8'hFE);
      end

      // R9: reset in mid-frame
      start = 1'b1;
      sdata = 1'b1;
      @(posedge clk);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         start = 1'b0;
         sdata = 1'b1;
         @(posedge clk);
      end
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(word == '0, "R9 word cleared by reset", word, 0);
      check(valid == 1'b0, "R9 valid low after reset", valid, 0);
      for (int c = 0; c < W + 2; c++) begin
         @(posedge clk);
         @(negedge clk);
         check(valid == 1'b0, "R9 abandoned frame gives no valid", valid, 0);
      end
      send(8'h96, 1'b0);
      check(valid == 1'b1 && word == 8'h96, "R9 frame after reset", word, 8'h96);
      start = 1'b0;
      @(posedge clk);
      @(negedge clk);

      finish_run();
   end
endmodule